// File: doc/BRIEF.md
# Prescaled Reloadable Down-Counter Timer

This block is a 16-bit down-counter that software sets up through four registers on a simple synchronous bus. Each count step comes from one of two sources. The first is the system clock divided by one of four prescaler ratios. The second is a rising edge on an external event pin, which is first resynchronised to the system clock.

When the count steps down from one to zero, this is a terminal count. On a terminal count the timer sets a sticky status flag and toggles an output pin. If its interrupt is enabled, it also raises an interrupt request.

In single-pass mode the timer stops at zero and clears its own enable. In continuous mode it reloads the programmed value and keeps running, so the output pin forms a square wave. Software reads the live count at any time without disturbing it. A read of the status register acknowledges the flag.

Top module: `reload_timer`

## Requirements
- R1: After reset, every register reads as zero, and `irq` and `timerOut` are low.
- R2: The register map is fixed.
  - Address 0 holds the reload value and is readable and writable.
  - Address 1 returns the live count; writes to it have no effect.
  - Address 2 is the control register, read and write: bit 0 enable, bit 1 continuous mode, bits 3:2 prescale code, bit 4 interrupt enable, bit 5 external source.
  - Address 3 returns the status flag in bit 0.
  - Read data is combinational from the registered state.
- R3: When software writes the enable bit from 0 to 1, the count loads the reload value in that cycle and the prescaler clears. Rewriting an enable that is already 1 does not reload the count.
- R4: With the internal source, the prescale code selects the division ratio: 0 gives 4, 1 gives 16, 2 gives 64 and 3 gives 256. The first decrement lands exactly one ratio of clock cycles after the enabling write, and each later decrement one ratio after the previous one.
- R5: A terminal count is a decrement while the count equals 1. In single-pass mode (bit 1 = 0), the count then holds 0 and the hardware clears the enable bit.
- R6: In continuous mode (bit 1 = 1), a terminal count loads the reload value, so terminal counts repeat every reload × ratio cycles. A reload value of 0 wraps through 0xFFFF and gives 65536 steps.
- R7: With the external source (bit 5 = 1), the pin passes through a two-flop synchronizer. Each rising edge decrements the count two clock edges after the pin is first sampled high. The prescaler then has no effect, and edges have no effect while the timer is disabled.
- R8: The status flag is set by a terminal count and stays set until a read of address 3. If a terminal count falls in the same cycle as the clearing read, the flag stays set.
- R9: `irq` is high exactly while the status flag is set and the interrupt enable bit is 1.
- R10: `timerOut` toggles on every terminal count and at no other time.
- R11: Reading the count does not disturb counting. A new reload value written while the timer runs first takes effect at the next terminal-count reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access strobe for this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for the addressed register |
| evtPin | input | 1 | External event input, asynchronous |
| irq | output | 1 | Interrupt request, level |
| timerOut | output | 1 | Output toggled on each terminal count |

## Verification
A terminal count and the read that clears the status flag can land on the same clock edge. The set must win, or an event is silently lost. The bench runs continuous mode with a reload of 1 and ratio 4, so terminal counts fall on a known edge every four cycles. It times a status read so that the read's clearing edge coincides with the second terminal count. It then judges the outcome from `irq` staying high and from the next status read still returning 1. A neighbouring read placed one cycle away from any terminal count confirms that the ordinary clear still works.

// File: rtl/timer_pkg.sv
package timer_pkg;

  localparam int TAP_W    = 2;
  localparam int NUM_TAPS = 2 ** TAP_W;
  localparam int TAP_STEP = 2;

  localparam logic [1:0] ADDR_RELOAD = 2'd0;
  localparam logic [1:0] ADDR_COUNT  = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;

  // Packed MSB first: extSrc is bit 5, enable is bit 0.
  typedef struct packed {
    logic             extSrc;
    logic             irqEn;
    logic [TAP_W-1:0] tap;
    logic             contMode;
    logic             enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef struct packed {
    logic             load;
    logic             run;
    logic             useExt;
    logic             contMode;
    logic [TAP_W-1:0] tap;
  } strobe_t;

endpackage

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             evtPin,
  output logic [CNT_W-1:0] countVal,
  output logic             tcEvt,
  output logic             timerOut
);

  localparam int PRESC_W = TAP_STEP * NUM_TAPS;

  logic [PRESC_W-1:0]   prescQ;
  logic [NUM_TAPS-1:0]  tapHit;
  logic [SYNC_STAGES:0] syncQ;
  logic [CNT_W-1:0]     countQ;
  logic                 outQ;
  logic                 extTick, intTick, tick, atOne;

  // Tap i fires once every 2**(TAP_STEP*(i+1)) prescaler cycles.
  for (genvar g = 0; g < NUM_TAPS; g++) begin : gTap
    assign tapHit[g] = &prescQ[TAP_STEP*(g+1)-1:0];
  end

  // The synchronizer chain plus one extra stage for rising-edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], evtPin};
  end

  assign extTick = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];
  assign intTick = tapHit[stb.tap];
  assign tick    = stb.run & ~stb.load & (stb.useExt ? extTick : intTick);
  assign atOne   = (countQ == CNT_W'(1));
  assign tcEvt   = tick & atOne;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        prescQ <= '0;
    else if (stb.load)                prescQ <= '0;
    else if (stb.run && !stb.useExt)  prescQ <= prescQ + PRESC_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (stb.load) begin
      countQ <= reloadVal;
    end else if (tick) begin
      if (atOne) countQ <= stb.contMode ? reloadVal : '0;
      else       countQ <= countQ - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      outQ <= 1'b0;
    else if (tcEvt) outQ <= ~outQ;
  end

  assign countVal = countQ;
  assign timerOut = outQ;

endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [1:0]       busAddr,
  input  logic [CNT_W-1:0] busWdata,
  output logic [CNT_W-1:0] busRdata,
  input  logic [CNT_W-1:0] countVal,
  input  logic             tcEvt,
  output strobe_t          stb,
  output ctrl_t            cfg,
  output logic [CNT_W-1:0] reloadVal,
  output logic             statusFlag,
  output logic             irq
);

  ctrl_t            cfgQ, newCfg;
  logic [CNT_W-1:0] reloadQ;
  logic             flagQ;
  logic             wrReload, wrCtrl, rdStatus;

  assign wrReload = busSel & busWr & (busAddr == ADDR_RELOAD);
  assign wrCtrl   = busSel & busWr & (busAddr == ADDR_CTRL);
  assign rdStatus = busSel & ~busWr & (busAddr == ADDR_STATUS);
  assign newCfg   = ctrl_t'(busWdata[CTRL_W-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         reloadQ <= '0;
    else if (wrReload) reloadQ <= busWdata;
  end

  // A software write wins over the hardware stop at the end of a single pass.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           cfgQ <= '0;
    else if (wrCtrl)                     cfgQ <= newCfg;
    else if (tcEvt && !cfgQ.contMode)    cfgQ.enable <= 1'b0;
  end

  // Set beats clear so that no terminal count is lost.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         flagQ <= 1'b0;
    else if (tcEvt)    flagQ <= 1'b1;
    else if (rdStatus) flagQ <= 1'b0;
  end

  always_comb begin
    stb          = '0;
    stb.load     = wrCtrl & newCfg.enable & ~cfgQ.enable;
    stb.run      = cfgQ.enable;
    stb.useExt   = cfgQ.extSrc;
    stb.contMode = cfgQ.contMode;
    stb.tap      = cfgQ.tap;
  end

  always_comb begin
    unique case (busAddr)
      ADDR_RELOAD: busRdata = reloadQ;
      ADDR_COUNT:  busRdata = countVal;
      ADDR_CTRL:   busRdata = {{(CNT_W-CTRL_W){1'b0}}, cfgQ};
      default:     busRdata = {{(CNT_W-1){1'b0}}, flagQ};
    endcase
  end

  assign cfg        = cfgQ;
  assign reloadVal  = reloadQ;
  assign statusFlag = flagQ;
  assign irq        = flagQ & cfgQ.irqEn;

endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [1:0]       busAddr,
  input  logic [CNT_W-1:0] busWdata,
  output logic [CNT_W-1:0] busRdata,
  input  logic             evtPin,
  output logic             irq,
  output logic             timerOut
);

  strobe_t          stb;
  ctrl_t            cfg;
  logic [CNT_W-1:0] reloadVal, countVal;
  logic             tcEvt, statusFlag;

  timer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .countVal(countVal), .tcEvt(tcEvt),
    .stb(stb), .cfg(cfg), .reloadVal(reloadVal),
    .statusFlag(statusFlag), .irq(irq)
  );

  timer_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN),
    .stb(stb), .reloadVal(reloadVal), .evtPin(evtPin),
    .countVal(countVal), .tcEvt(tcEvt), .timerOut(timerOut)
  );

endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busWr,
  input logic [1:0]       busAddr,
  input logic             irq,
  input logic             timerOut,
  input ctrl_t            cfg,
  input logic [CNT_W-1:0] reloadVal,
  input logic [CNT_W-1:0] countVal,
  input logic             tcEvt,
  input logic             statusFlag
);

  logic ctrlWrite, statusRead;
  assign ctrlWrite  = busSel & busWr & (busAddr == 2'd2);
  assign statusRead = busSel & ~busWr & (busAddr == 2'd3);

  // R1
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rstN) |-> (!irq && !timerOut));

  // R3
  a_r3_enable_loads: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfg.enable) |-> countVal == $past(reloadVal));

  // R5
  a_r5_single_stops: assert property (@(posedge clk) disable iff (!rstN)
    (tcEvt && !cfg.contMode && !ctrlWrite) |=> (!cfg.enable && countVal == '0));

  // R6
  a_r6_cont_reloads: assert property (@(posedge clk) disable iff (!rstN)
    (tcEvt && cfg.contMode) |=> countVal == $past(reloadVal));

  // R8
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ($past(statusFlag) && !$past(statusRead)) |-> statusFlag);

  // R8
  a_r8_tc_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    tcEvt |=> statusFlag);

  // R9
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusFlag && cfg.irqEn));

  // R10
  a_r10_out_on_tc_only: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(timerOut) |-> $past(tcEvt));

endmodule

bind reload_timer reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .irq(irq), .timerOut(timerOut),
  .cfg(cfg), .reloadVal(reloadVal), .countVal(countVal),
  .tcEvt(tcEvt), .statusFlag(statusFlag)
);

// File: tb/tb_reload_timer.sv
module tb_reload_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [15:0] busWdata = 16'd0;
  logic [15:0] busRdata;
  logic        evtPin = 1'b0;
  logic        irq, timerOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  reload_timer dut (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .evtPin(evtPin), .irq(irq), .timerOut(timerOut)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next posedge; returns at the following negedge.
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  // Samples the state left by the last posedge and consumes one posedge.
  task automatic rd(input logic [1:0] a, output int d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = int'(busRdata);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic evtPulse();
    evtPin = 1'b1; waitN(3);
    evtPin = 1'b0; waitN(3);
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 register after reset", v, 0);
    end
    check("R1 irq after reset", int'(irq), 0);
    check("R1 timerOut after reset", int'(timerOut), 0);
  endtask

  task automatic t_single_div4();
    int v;
    wr(2'd0, 16'd3);
    rd(2'd0, v); check("R2 reload readback", v, 3);
    wr(2'd2, 16'h0011);                 // enable write at P0
    rd(2'd1, v); check("R3 count loaded", v, 3);
    waitN(2);
    rd(2'd1, v); check("R4 no decrement before 4 cycles", v, 3);
    rd(2'd1, v); check("R4 decrement at 4 cycles", v, 2);
    waitN(6);                           // after P11
    check("R9 irq before terminal", int'(irq), 0);
    check("R10 out before terminal", int'(timerOut), 0);
    waitN(1);                           // after P12
    check("R9 irq at terminal", int'(irq), 1);
    check("R10 out toggled", int'(timerOut), 1);
    rd(2'd1, v); check("R5 count holds zero", v, 0);
    rd(2'd2, v); check("R5 enable cleared", v, 16'h0010);
    waitN(10);
    rd(2'd1, v); check("R5 stays stopped", v, 0);
    rd(2'd3, v); check("R8 flag set", v, 1);
    rd(2'd3, v); check("R8 flag cleared by read", v, 0);
    check("R9 irq follows flag", int'(irq), 0);
  endtask

  task automatic t_cont_div16();
    int v;
    wr(2'd0, 16'd2);
    wr(2'd2, 16'h0007);                 // P0
    waitN(31);
    check("R6 out before first terminal", int'(timerOut), 1);
    waitN(1);                           // after P32
    check("R6 out toggled at 32", int'(timerOut), 0);
    check("R9 irq masked when disabled", int'(irq), 0);
    rd(2'd1, v); check("R6 reloaded", v, 2);      // now after P33
    rd(2'd3, v); check("R8 flag set masked", v, 1); // cleared at P34
    waitN(29);                          // after P63
    check("R6 out holds mid-period", int'(timerOut), 0);
    waitN(1);                           // after P64
    check("R10 second toggle", int'(timerOut), 1);
    rd(2'd3, v); check("R6 flag set again", v, 1);
    wr(2'd2, 16'h0000);
  endtask

  task automatic t_taps_64_256();
    int v;
    wr(2'd0, 16'd1);
    wr(2'd2, 16'h0019);                 // tap 2, single, irqEn
    waitN(63);
    check("R4 /64 not yet", int'(irq), 0);
    waitN(1);
    check("R4 /64 terminal", int'(irq), 1);
    check("R10 toggle /64", int'(timerOut), 0);
    rd(2'd3, v);
    wr(2'd2, 16'h001D);                 // tap 3, enable again from 0
    waitN(255);
    check("R4 /256 not yet", int'(irq), 0);
    waitN(1);
    check("R4 /256 terminal", int'(irq), 1);
    check("R10 toggle /256", int'(timerOut), 1);
    rd(2'd3, v);
  endtask

  task automatic t_external();
    int v;
    wr(2'd0, 16'd3);
    wr(2'd2, 16'h0023);                 // ext, continuous, enable
    waitN(300);
    rd(2'd1, v); check("R7 prescaler unused in ext mode", v, 3);
    evtPin = 1'b1;
    waitN(2);
    rd(2'd1, v); check("R7 no step before sync", v, 3);
    rd(2'd1, v); check("R7 step after two edges", v, 2);
    evtPin = 1'b0; waitN(3);
    evtPulse();
    rd(2'd1, v); check("R7 second event", v, 1);
    evtPulse();
    rd(2'd1, v); check("R6 ext reload", v, 3);
    check("R10 toggle on ext terminal", int'(timerOut), 0);
    rd(2'd3, v); check("R8 flag from ext", v, 1);
    wr(2'd2, 16'h0022);                 // disable
    evtPulse();
    rd(2'd1, v); check("R7 ignored when disabled", v, 3);
    check("R7 out unchanged when disabled", int'(timerOut), 0);
  endtask

  task automatic t_collision();
    int v;
    wr(2'd0, 16'd1);
    wr(2'd2, 16'h0013);                 // P0; terminals at P4, P8, P12
    waitN(7);
    rd(2'd3, v);                        // clears at P8 = terminal
    check("R8 flag seen before collision", v, 1);
    check("R8 irq survives collision", int'(irq), 1);
    rd(2'd3, v); check("R8 set wins over clear", v, 1);
    rd(2'd3, v); check("R8 plain clear", v, 0);
    wr(2'd2, 16'h0000);
    rd(2'd3, v);
  endtask

  task automatic t_reload_change();
    int v;
    wr(2'd0, 16'd4);
    wr(2'd2, 16'h0003);                 // P0, /4 continuous
    waitN(5);                           // after P5
    wr(2'd0, 16'd9);                    // P6
    wr(2'd1, 16'h0055);                 // P7, ignored
    rd(2'd1, v); check("R11 reload write does not touch count", v, 3);
    wr(2'd2, 16'h0003);                 // P9, already enabled
    rd(2'd1, v); check("R3 no reload when enable stays 1", v, 2);
    waitN(6);                           // after P16
    rd(2'd1, v); check("R11 new reload at terminal", v, 9);
    wr(2'd2, 16'h0000);
  endtask

  initial begin
    waitN(3);
    rstN = 1'b1;
    waitN(2);
    t_reset();
    t_single_div4();
    t_cont_div16();
    t_taps_64_256();
    t_external();
    t_collision();
    t_reload_change();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule